// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches a bank of external lines and turns selected transitions on them into interrupt requests and event pulses for two processor cores. Each line is brought into the clock domain through a two-flop synchronizer. A third flop keeps the last sampled level, which gives rising and falling edge detection. Software picks, per line, which edge polarities count. It can also fire any line directly through a software trigger register.

Each core owns a private context of three registers: an interrupt mask, an event mask and a pending register. A qualifying line sets the core's pending bit only when that core's interrupt mask bit is set. The core's interrupt output stays high while any unmasked pending bit remains. The event mask works apart from the interrupt mask: it yields a one-clock event pulse and never touches the pending state. Software clears pending bits by writing ones to them. All registers sit on a simple word-indexed read/write bus with combinational read data.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A 0-to-1 change on `line_in[i]` with bit i set in the rise-enable register (index 0) sets bit i of a core's pending register on the third rising clock edge after the change, and not earlier.
- R2: A 1-to-0 change counts when bit i of the fall-enable register (index 1) is set. With both enables set, either polarity counts. With neither set, no change on the line has any effect.
- R3: A qualifying line sets a pending bit only for a core whose interrupt-mask bit i is set (core A mask at index 3, core B mask at index 6). The core's interrupt output is high exactly while some bit is set in both its pending and interrupt-mask registers.
- R4: Writing a word to a pending register (core A at index 5, core B at index 8) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a qualifying line and a clearing write to the same pending bit land in the same clock cycle, the bit stays set.
- R6: Writing 1 to bit i of the software trigger register (index 2) qualifies line i in that cycle, whatever its edge enables are. The register always reads as zero.
- R7: A qualifying line with its event-mask bit set (core A at index 4, core B at index 7) drives that core's event output high for exactly one clock, starting at the same edge that would set pending. Events alone never set a pending bit.
- R8: Lines without event support (by default the top 8 lines, 24 to 31) ignore writes of 1 to their event-mask bits, which always read as 0.
- R9: The two cores' mask and pending registers are independent. A write to or a trigger through one core's registers never changes the other core's registers or outputs.
- R10: After reset, every register reads as zero and both interrupt and both event outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 32 | Asynchronous external lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_a | output | 1 | Interrupt request to core A |
| evt_a | output | 1 | One-cycle event pulse to core A |
| irq_b | output | 1 | Interrupt request to core B |
| evt_b | output | 1 | One-cycle event pulse to core B |

## Verification
The bench drives an edge into the same cycle as a clearing write. A design that let the clear win would lose that interrupt. It also samples pending one edge before it is due, which catches a synchronizer that is one flop short. It fires lines whose edge enables are off or set to the other polarity, which shows up a detector that ignores polarity. It also uses an event-only line, which shows up an event path that sets pending by mistake. It writes ones to event-mask bits of lines that lack event support and reads them back. It also triggers core A and then checks that core B's pending register and interrupt stay unchanged, which catches shared or crossed context registers.

// File: rtl/edge_irq_pkg.sv
// Shared register indices and address type for the edge interrupt controller.
package edge_irq_pkg;
    localparam int ADDR_W = 4;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t REG_RISE    = 4'd0;
    localparam reg_addr_t REG_FALL    = 4'd1;
    localparam reg_addr_t REG_SWTRIG  = 4'd2;
    localparam reg_addr_t REG_IMASK_A = 4'd3;  // core contexts are three words each
    localparam reg_addr_t REG_EMASK_A = 4'd4;
    localparam reg_addr_t REG_PEND_A  = 4'd5;
    localparam reg_addr_t REG_IMASK_B = 4'd6;
    localparam reg_addr_t REG_EMASK_B = 4'd7;
    localparam reg_addr_t REG_PEND_B  = 4'd8;
    localparam int        CTX_STRIDE  = 3;
endpackage

// File: rtl/edge_sync_detect.sv
// Synchronizes asynchronous lines with two flops and flags single-cycle
// rising and falling transitions against the last sampled level.
// Assumes each input stays stable for at least two clocks between changes.
module edge_sync_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q, sync_q, last_q;

    // Synchronizer chain plus the previous-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;
    assign fall = ~sync_q & last_q;
endmodule

// File: rtl/trig_cfg.sv
// Holds per-line rising/falling enables and merges qualified edges with
// software triggers into one per-line hit vector. Software trigger writes
// act only in the cycle of the write and are not stored.
module trig_cfg
    import edge_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  reg_addr_t    addr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] fall,
    output logic [N-1:0] rise_en,
    output logic [N-1:0] fall_en,
    output logic [N-1:0] hit
);
    logic [N-1:0] sw_pulse;

    // Edge-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
        end else if (we) begin
            if (addr == REG_RISE) rise_en <= wdata;
            if (addr == REG_FALL) fall_en <= wdata;
        end
    end

    // Software trigger is a write-cycle pulse; qualified edges join it.
    always_comb begin
        sw_pulse = (we && addr == REG_SWTRIG) ? wdata : '0;
        hit      = (rise & rise_en) | (fall & fall_en) | sw_pulse;
    end
endmodule

// File: rtl/core_ctx.sv
// One core's interrupt mask, event mask and pending register, with its
// interrupt level and registered one-cycle event pulse. Pending bits are
// write-1-to-clear; a same-cycle hit overrides a clear.
module core_ctx
    import edge_irq_pkg::*;
#(
    parameter int              N          = 32,
    parameter logic [N-1:0]    EVT_OK     = '1,
    parameter reg_addr_t       IMASK_ADDR = REG_IMASK_A,
    parameter reg_addr_t       EMASK_ADDR = REG_EMASK_A,
    parameter reg_addr_t       PEND_ADDR  = REG_PEND_A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  reg_addr_t    addr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] hit,
    output logic [N-1:0] imask,
    output logic [N-1:0] emask,
    output logic [N-1:0] pend,
    output logic         irq,
    output logic         evt
);
    logic [N-1:0] clr;

    // Decode the clear mask for this core's pending register.
    always_comb clr = (we && addr == PEND_ADDR) ? wdata : '0;

    // Mask registers; unsupported event lines are forced off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask <= '0;
            emask <= '0;
        end else if (we) begin
            if (addr == IMASK_ADDR) imask <= wdata;
            if (addr == EMASK_ADDR) emask <= wdata & EVT_OK;
        end
    end

    // Pending update: clear first, then new masked hits set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | (hit & imask);
    end

    // Event pulse, one clock per qualifying cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= |(hit & emask);
    end

    assign irq = |(pend & imask);
endmodule

// File: rtl/edge_irq_ctrl.sv
// Top of the edge interrupt/event controller: line synchronizer, shared
// trigger configuration, two generated core contexts and a read mux.
// Assumes a single-cycle write bus and combinational reads.
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES    = 32,
    parameter int NO_EVT_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_a,
    output logic                 evt_a,
    output logic                 irq_b,
    output logic                 evt_b
);
    localparam logic [NUM_LINES-1:0] EVT_CAPABLE = {NUM_LINES{1'b1}} >> NO_EVT_LINES;
    localparam int NCORE = 2;

    logic [NUM_LINES-1:0] rise, fall, hit, rise_en, fall_en;
    logic [NUM_LINES-1:0] imask_v [NCORE];
    logic [NUM_LINES-1:0] emask_v [NCORE];
    logic [NUM_LINES-1:0] pend_v  [NCORE];
    logic [NCORE-1:0]     irq_v, evt_v;
    logic [NUM_LINES-1:0] pend_a, pend_b, imask_a, emask_a;

    edge_sync_detect #(.N(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(line_in), .rise(rise), .fall(fall)
    );

    trig_cfg #(.N(NUM_LINES)) u_trig (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rise(rise), .fall(fall),
        .rise_en(rise_en), .fall_en(fall_en), .hit(hit)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        localparam reg_addr_t BASE = reg_addr_t'(int'(REG_IMASK_A) + CTX_STRIDE * c);
        core_ctx #(
            .N(NUM_LINES), .EVT_OK(EVT_CAPABLE),
            .IMASK_ADDR(BASE), .EMASK_ADDR(BASE + 4'd1), .PEND_ADDR(BASE + 4'd2)
        ) u_ctx (
            .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
            .wdata(bus_wdata), .hit(hit),
            .imask(imask_v[c]), .emask(emask_v[c]), .pend(pend_v[c]),
            .irq(irq_v[c]), .evt(evt_v[c])
        );
    end

    assign irq_a   = irq_v[0];
    assign evt_a   = evt_v[0];
    assign irq_b   = irq_v[1];
    assign evt_b   = evt_v[1];
    assign pend_a  = pend_v[0];
    assign pend_b  = pend_v[1];
    assign imask_a = imask_v[0];
    assign emask_a = emask_v[0];

    // Register read mux; the trigger register and unused indices read zero.
    always_comb begin
        case (bus_addr)
            REG_RISE:    bus_rdata = rise_en;
            REG_FALL:    bus_rdata = fall_en;
            REG_IMASK_A: bus_rdata = imask_v[0];
            REG_EMASK_A: bus_rdata = emask_v[0];
            REG_PEND_A:  bus_rdata = pend_v[0];
            REG_IMASK_B: bus_rdata = imask_v[1];
            REG_EMASK_B: bus_rdata = emask_v[1];
            REG_PEND_B:  bus_rdata = pend_v[1];
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
// Temporal checks on the controller, attached by bind to every instance.
module edge_irq_ctrl_chk
    import edge_irq_pkg::*;
#(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input reg_addr_t    bus_addr,
    input logic [N-1:0] pend_a,
    input logic [N-1:0] pend_b,
    input logic [N-1:0] imask_a,
    input logic [N-1:0] emask_a,
    input logic         irq_a,
    input logic         evt_a
);
    AST_PEND_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == REG_PEND_A) |=> ((pend_a & $past(pend_a)) == $past(pend_a))); // R4
    AST_PEND_B_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == REG_PEND_B) |=> ((pend_b & $past(pend_b)) == $past(pend_b))); // R9
    AST_PEND_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_a & ~$past(pend_a) & ~$past(imask_a)) == '0)); // R3
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a == '0) |-> !irq_a); // R3
    AST_EVT_NEEDS_EMASK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a |-> ($past(emask_a) != '0)); // R7
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.N(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .pend_a(pend_a), .pend_b(pend_b), .imask_a(imask_a), .emask_a(emask_a),
    .irq_a(irq_a), .evt_a(evt_a)
);

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_edge_irq_ctrl;
    import edge_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_in = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a, evt_a, irq_b, evt_b;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;  // 125 MHz

    edge_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_a(irq_a), .evt_a(evt_a), .irq_b(irq_b), .evt_b(evt_b)
    );

    // Row: line[11:7] rise_en[6] fall_en[5] imask[4] emask[3] rising[2] exp_pend[1] exp_evt[0]
    localparam logic [11:0] VEC [9] = '{
        {5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 rising counts
        {5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 wrong polarity
        {5'd7,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 falling counts
        {5'd12, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 both, R7 event
        {5'd20, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 both, rising
        {5'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 no enables
        {5'd9,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R7 event only, R3
        {5'd31, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R8 no event support
        {5'd23, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}   // R8 last capable line
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write lands on the posedge after the current negedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 9; a++) begin
            rd(a[3:0], rv);
            check("R10 register reset", rv, 32'h0);
        end
        check("R10 outputs low", {28'h0, irq_a, evt_a, irq_b, evt_b}, 32'h0);

        // Table walk, core A
        for (int i = 0; i < 9; i++) begin
            logic [4:0]  ln;
            logic [31:0] bit_m;
            logic        rising;
            ln     = VEC[i][11:7];
            bit_m  = 32'h1 << ln;
            rising = VEC[i][2];
            wr(REG_RISE, '0);
            wr(REG_FALL, '0);
            line_in[ln] = ~rising;
            repeat (4) @(negedge clk);
            wr(REG_RISE,    VEC[i][6] ? bit_m : '0);
            wr(REG_FALL,    VEC[i][5] ? bit_m : '0);
            wr(REG_IMASK_A, VEC[i][4] ? bit_m : '0);
            wr(REG_EMASK_A, VEC[i][3] ? bit_m : '0);
            wr(REG_PEND_A,  '1);
            line_in[ln] = rising;
            repeat (3) @(negedge clk);
            check($sformatf("R7 row %0d event", i), {31'h0, evt_a}, {31'h0, VEC[i][0]});
            rd(REG_PEND_A, rv);
            check($sformatf("R1 R2 row %0d pending", i), rv, VEC[i][1] ? bit_m : '0);
            @(negedge clk);
            check($sformatf("R7 row %0d pulse ends", i), {31'h0, evt_a}, 32'h0);
        end

        // R8: event mask of unsupported lines
        wr(REG_EMASK_A, '1);
        rd(REG_EMASK_A, rv);
        check("R8 event mask readback", rv, 32'h00FF_FFFF);
        wr(REG_EMASK_A, '0);

        // R6/R3: software trigger ignores enables, raises irq
        wr(REG_RISE, '0);
        wr(REG_FALL, '0);
        wr(REG_PEND_A, '1);
        wr(REG_IMASK_A, 32'h4);
        wr(REG_SWTRIG, 32'h4);
        rd(REG_PEND_A, rv);
        check("R6 software trigger sets pending", rv, 32'h4);
        check("R3 irq_a high", {31'h0, irq_a}, 32'h1);
        rd(REG_SWTRIG, rv);
        check("R6 trigger reads zero", rv, 32'h0);

        // R9: core B untouched
        rd(REG_PEND_B, rv);
        check("R9 core B pending unaffected", rv, 32'h0);
        check("R9 irq_b low", {31'h0, irq_b}, 32'h0);
        wr(REG_IMASK_B, 32'h4);
        wr(REG_SWTRIG, 32'h4);
        wr(REG_PEND_A, 32'h4);
        rd(REG_PEND_B, rv);
        check("R9 core B keeps pending after A clear", rv, 32'h4);
        check("R9 irq_b high", {31'h0, irq_b}, 32'h1);

        // R4: write-one-to-clear, zero has no effect
        wr(REG_SWTRIG, 32'h4);
        wr(REG_PEND_A, 32'h0);
        rd(REG_PEND_A, rv);
        check("R4 zero write keeps pending", rv, 32'h4);
        wr(REG_PEND_A, 32'h4);
        rd(REG_PEND_A, rv);
        check("R4 one write clears", rv, 32'h0);
        check("R3 irq_a low after clear", {31'h0, irq_a}, 32'h0);

        // R1: latency of three edges
        wr(REG_IMASK_A, 32'h0001_0000);
        wr(REG_RISE, 32'h0001_0000);
        line_in[16] = 1'b1;
        repeat (2) @(negedge clk);
        rd(REG_PEND_A, rv);
        check("R1 not pending after two edges", rv, 32'h0);
        @(negedge clk);
        rd(REG_PEND_A, rv);
        check("R1 pending after third edge", rv, 32'h0001_0000);

        // R5: edge and clear in the same cycle
        wr(REG_PEND_A, '1);
        wr(REG_IMASK_A, 32'h8000);
        wr(REG_RISE, 32'h8000);
        wr(REG_SWTRIG, 32'h8000);
        line_in[15] = 1'b1;
        repeat (2) @(negedge clk);
        wr(REG_PEND_A, 32'h8000);
        rd(REG_PEND_A, rv);
        check("R5 edge wins over clear", rv, 32'h8000);

        finish_run();
    end
endmodule